// File: doc/BRIEF.md
# Oscillator and Dual PLL Control Unit

This block holds the software-visible control of four clock sources: a main crystal oscillator, a slow crystal oscillator and two PLLs. Software reaches it through a small register port with a write strobe and a combinational read path. Three control words live at fixed offsets: one for the crystals, one for the PLLs and one for the PLL frequency settings. The block drives a run output for each source. It reports a stable flag for the main crystal, PLL1 and PLL2, and it decodes the frequency word into multiplier, shift and rate outputs.

The main crystal and PLL1 stay under hardware control, and so keep running, until software sets their override bit. Only then does the matching software enable bit decide whether they run. Clearing the override hands the main crystal back to hardware and restarts it at once, which a warm restart needs. PLL2 follows its enable bit directly. The slow crystal runs unless its disable bit is set. The analog circuits are modelled by lock sequencers. Each sequencer is a three-state machine: OFF, SETTLE and LOCKED. OFF moves to SETTLE on the first edge at which the run input is high. SETTLE moves to LOCKED once a counter has seen `LOCK_CYCLES` edges with its timer-enable bit set, and the counter holds while that bit is clear. SETTLE and LOCKED both fall back to OFF when the run input drops.

The rate outputs give the PLL1 output rate as the reference rate times (field+2), shifted right by the divider field. PLL2 has a multiplier only. A bench can therefore check the arithmetic without a real clock.

Top module: `osc_pll_ctrl`

## Requirements
- R1: Offset 0x0C reads the crystal word, 0x10 the PLL word and 0x14 the frequency word. Bits without a field read 0, any other offset reads 0, and a write to any other offset changes nothing.
- R2: In the crystal word, bit 0 is the main-crystal override and bit 1 its enable. `main_xtal_run` is 1 whenever bit 0 is 0. When bit 0 is 1, `main_xtal_run` equals bit 1. Clearing bit 0 restarts the crystal on the cycle after the write, whatever bit 1 holds.
- R3: In the PLL word, bit 0 is the PLL1 override and bit 1 its enable. `pll1_run` is 1 whenever bit 0 is 0. When bit 0 is 1, `pll1_run` equals bit 1.
- R4: `pll2_run` equals bit 28 of the PLL word. `slow_xtal_run` is the inverse of bit 19 of the crystal word.
- R5: The first clock edge on which a source's run output is 1 moves its sequencer from OFF to SETTLE. The stable flag then rises after a further `LOCK_CYCLES` edges on which the matching timer-enable bit is 1.
- R6: Bit 20 of the crystal word is the timer enable for the main crystal. Bit 29 of the PLL word is the timer enable for both PLLs. While a timer enable is 0, a settling source never becomes stable.
- R7: A stable flag drops in the same cycle as its run output.
- R8: Bit 2 of the crystal word reads the main-crystal stable flag, and bit 2 of the PLL word reads the PLL1 stable flag. Writes to these bits have no effect.
- R9: The PLL1 multiplier is bits 13:8 of the frequency word plus 2. The PLL1 shift is bits 2:0. `pll1_rate` = (`ref_rate` × multiplier) >> shift.
- R10: The PLL2 multiplier is bits 29:24 of the frequency word plus 2, and `pll2_rate` = `ref_rate` × multiplier.
- R11: After reset both timer enables are 1 and every other stored bit is 0. So the main crystal, PLL1 and the slow crystal run, PLL2 is off, and all stable flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ref_rate | input | RATE_W | Reference rate fed to both PLLs |
| main_xtal_run | output | 1 | Main crystal running |
| slow_xtal_run | output | 1 | Slow crystal running |
| pll1_run | output | 1 | PLL1 running |
| pll2_run | output | 1 | PLL2 running |
| main_xtal_ok | output | 1 | Main crystal stable |
| pll1_ok | output | 1 | PLL1 stable |
| pll2_ok | output | 1 | PLL2 stable |
| pll1_mul | output | 7 | PLL1 multiplier |
| pll1_shift | output | 3 | PLL1 right shift |
| pll2_mul | output | 7 | PLL2 multiplier |
| pll1_rate | output | RATE_W+7 | PLL1 output rate |
| pll2_rate | output | RATE_W+7 | PLL2 output rate |

## Verification
The bench builds the block with `LOCK_CYCLES` = 5 and `RATE_W` = 16. The short settle window lets the bench pin the exact edge on which each stable flag rises. It also lets the bench hold a source in SETTLE for several windows with its timer gated off, then watch the flag rise exactly five timed edges after the gate reopens. With a 16-bit reference, the largest multiplier and shift produce rates that fill the 23-bit outputs, so truncation in the product or the shift shows up.

// File: rtl/osc_pll_pkg.sv
package osc_pll_pkg;

    localparam int REG_W     = 32;
    localparam int MF_W      = 6;
    localparam int SH_W      = 3;
    localparam int MUL_W     = 7;
    localparam int MUL_BIAS  = 2;

    // register offsets
    localparam logic [7:0] OFS_XTAL = 8'h0C;
    localparam logic [7:0] OFS_PLL  = 8'h10;
    localparam logic [7:0] OFS_FREQ = 8'h14;

    // crystal word bit positions
    localparam int XB_OVR  = 0;
    localparam int XB_EN   = 1;
    localparam int XB_STAT = 2;
    localparam int XB_SDIS = 19;
    localparam int XB_TMR  = 20;

    // PLL word bit positions
    localparam int PB_OVR   = 0;
    localparam int PB_EN    = 1;
    localparam int PB_STAT  = 2;
    localparam int PB_P2EN  = 28;
    localparam int PB_TMR   = 29;

    // frequency word field positions
    localparam int FB_P1SH = 0;
    localparam int FB_P1MF = 8;
    localparam int FB_P2MF = 24;

    typedef enum logic [1:0] {
        LS_OFF    = 2'd0,
        LS_SETTLE = 2'd1,
        LS_LOCKED = 2'd2
    } lock_st_e;

endpackage

// File: rtl/osc_lock_seq.sv
module osc_lock_seq
    import osc_pll_pkg::*;
#(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tmr_i,
    output logic ok_o
);

    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

    lock_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LS_OFF: begin
                cnt_d = '0;
                if (run_i) begin
                    state_d = LS_SETTLE;
                end
            end
            LS_SETTLE: begin
                if (!run_i) begin
                    state_d = LS_OFF;
                    cnt_d   = '0;
                end else if (tmr_i) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = LS_LOCKED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            LS_LOCKED: begin
                if (!run_i) begin
                    state_d = LS_OFF;
                end
            end
            default: begin
                state_d = LS_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs: the flag drops with run in the same cycle
    always_comb begin
        ok_o = (state_q == LS_LOCKED) && run_i;
    end

endmodule

// File: rtl/osc_pll_regs.sv
module osc_pll_regs
    import osc_pll_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              stat_xtal,
    input  logic              stat_pll1,
    output logic [REG_W-1:0]  rdata,
    output logic              xtal_ovr,
    output logic              xtal_en,
    output logic              sxtal_dis,
    output logic              xtal_tmr,
    output logic              pll1_ovr,
    output logic              pll1_en,
    output logic              pll2_en,
    output logic              pll_tmr,
    output logic [MF_W-1:0]   p1_mf,
    output logic [SH_W-1:0]   p1_sh,
    output logic [MF_W-1:0]   p2_mf
);

    localparam logic [ADDR_W-1:0] A_XTAL = ADDR_W'(OFS_XTAL);
    localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(OFS_PLL);
    localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(OFS_FREQ);

    logic hit_xtal, hit_pll, hit_freq;
    logic unused_wdata;

    assign hit_xtal     = (addr == A_XTAL);
    assign hit_pll      = (addr == A_PLL);
    assign hit_freq     = (addr == A_FREQ);
    assign unused_wdata = &{1'b0, wdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xtal_ovr  <= 1'b0;
            xtal_en   <= 1'b0;
            sxtal_dis <= 1'b0;
            xtal_tmr  <= 1'b1;
            pll1_ovr  <= 1'b0;
            pll1_en   <= 1'b0;
            pll2_en   <= 1'b0;
            pll_tmr   <= 1'b1;
            p1_mf     <= '0;
            p1_sh     <= '0;
            p2_mf     <= '0;
        end else if (wr) begin
            if (hit_xtal) begin
                xtal_ovr  <= wdata[XB_OVR];
                xtal_en   <= wdata[XB_EN];
                sxtal_dis <= wdata[XB_SDIS];
                xtal_tmr  <= wdata[XB_TMR];
            end
            if (hit_pll) begin
                pll1_ovr <= wdata[PB_OVR];
                pll1_en  <= wdata[PB_EN];
                pll2_en  <= wdata[PB_P2EN];
                pll_tmr  <= wdata[PB_TMR];
            end
            if (hit_freq) begin
                p1_sh <= wdata[FB_P1SH +: SH_W];
                p1_mf <= wdata[FB_P1MF +: MF_W];
                p2_mf <= wdata[FB_P2MF +: MF_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_xtal) begin
            rdata[XB_OVR]  = xtal_ovr;
            rdata[XB_EN]   = xtal_en;
            rdata[XB_STAT] = stat_xtal;
            rdata[XB_SDIS] = sxtal_dis;
            rdata[XB_TMR]  = xtal_tmr;
        end else if (hit_pll) begin
            rdata[PB_OVR]  = pll1_ovr;
            rdata[PB_EN]   = pll1_en;
            rdata[PB_STAT] = stat_pll1;
            rdata[PB_P2EN] = pll2_en;
            rdata[PB_TMR]  = pll_tmr;
        end else if (hit_freq) begin
            rdata[FB_P1SH +: SH_W] = p1_sh;
            rdata[FB_P1MF +: MF_W] = p1_mf;
            rdata[FB_P2MF +: MF_W] = p2_mf;
        end
    end

endmodule

// File: rtl/osc_pll_ratio.sv
module osc_pll_ratio
    import osc_pll_pkg::*;
#(
    parameter int RATE_W  = 16,
    parameter bit HAS_DIV = 1'b1,
    localparam int OUT_W  = RATE_W + MUL_W
) (
    input  logic [MF_W-1:0]   mf,
    input  logic [SH_W-1:0]   sh,
    input  logic [RATE_W-1:0] ref_rate,
    output logic [MUL_W-1:0]  mul,
    output logic [SH_W-1:0]   shift,
    output logic [OUT_W-1:0]  rate
);

    logic [OUT_W-1:0] prod;

    assign shift = HAS_DIV ? sh : '0;
    assign mul   = MUL_W'(mf) + MUL_W'(MUL_BIAS);
    assign prod  = OUT_W'(ref_rate) * OUT_W'(mul);
    assign rate  = prod >> shift;

endmodule

// File: rtl/osc_pll_ctrl.sv
module osc_pll_ctrl
    import osc_pll_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int RATE_W      = 16,
    parameter int LOCK_CYCLES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    input  logic [RATE_W-1:0]         ref_rate,
    output logic                      main_xtal_run,
    output logic                      slow_xtal_run,
    output logic                      pll1_run,
    output logic                      pll2_run,
    output logic                      main_xtal_ok,
    output logic                      pll1_ok,
    output logic                      pll2_ok,
    output logic [MUL_W-1:0]          pll1_mul,
    output logic [SH_W-1:0]           pll1_shift,
    output logic [MUL_W-1:0]          pll2_mul,
    output logic [RATE_W+MUL_W-1:0]   pll1_rate,
    output logic [RATE_W+MUL_W-1:0]   pll2_rate
);

    localparam int NSEQ = 3;

    logic xtal_ovr, xtal_en, sxtal_dis, xtal_tmr;
    logic pll1_ovr, pll1_en, pll2_en, pll_tmr;
    logic [MF_W-1:0] p1_mf, p2_mf;
    logic [SH_W-1:0] p1_sh;
    logic [SH_W-1:0] p2_shift_unused;
    logic [NSEQ-1:0] seq_run, seq_tmr, seq_ok;

    osc_pll_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .stat_xtal (seq_ok[0]),
        .stat_pll1 (seq_ok[1]),
        .rdata     (reg_rdata),
        .xtal_ovr  (xtal_ovr),
        .xtal_en   (xtal_en),
        .sxtal_dis (sxtal_dis),
        .xtal_tmr  (xtal_tmr),
        .pll1_ovr  (pll1_ovr),
        .pll1_en   (pll1_en),
        .pll2_en   (pll2_en),
        .pll_tmr   (pll_tmr),
        .p1_mf     (p1_mf),
        .p1_sh     (p1_sh),
        .p2_mf     (p2_mf)
    );

    // hardware keeps a source running until its override is set
    assign main_xtal_run = !xtal_ovr || xtal_en;
    assign pll1_run      = !pll1_ovr || pll1_en;
    assign pll2_run      = pll2_en;
    assign slow_xtal_run = !sxtal_dis;

    assign seq_run = {pll2_run, pll1_run, main_xtal_run};
    assign seq_tmr = {pll_tmr, pll_tmr, xtal_tmr};

    for (genvar g = 0; g < NSEQ; g++) begin : g_seq
        osc_lock_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (seq_run[g]),
            .tmr_i (seq_tmr[g]),
            .ok_o  (seq_ok[g])
        );
    end

    assign main_xtal_ok = seq_ok[0];
    assign pll1_ok      = seq_ok[1];
    assign pll2_ok      = seq_ok[2];

    osc_pll_ratio #(.RATE_W(RATE_W), .HAS_DIV(1'b1)) u_ratio1 (
        .mf       (p1_mf),
        .sh       (p1_sh),
        .ref_rate (ref_rate),
        .mul      (pll1_mul),
        .shift    (pll1_shift),
        .rate     (pll1_rate)
    );

    osc_pll_ratio #(.RATE_W(RATE_W), .HAS_DIV(1'b0)) u_ratio2 (
        .mf       (p2_mf),
        .sh       ('0),
        .ref_rate (ref_rate),
        .mul      (pll2_mul),
        .shift    (p2_shift_unused),
        .rate     (pll2_rate)
    );

endmodule

// File: rtl/osc_pll_ctrl_chk.sv
module osc_pll_ctrl_chk
    import osc_pll_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              main_xtal_run,
    input logic              pll2_run,
    input logic              main_xtal_ok,
    input logic              pll1_ok,
    input logic              pll2_ok,
    input logic              pll_tmr,
    input logic [MUL_W-1:0]  pll1_mul
);

    localparam logic [ADDR_W-1:0] A_XTAL = ADDR_W'(OFS_XTAL);
    localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(OFS_PLL);

    p_ovr_clear_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_XTAL && !reg_wdata[XB_OVR]) |=> main_xtal_run);

    p_pll2_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_PLL) |=> (pll2_run == $past(reg_wdata[PB_P2EN])));

    p_lock_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_xtal_ok) |-> $past(main_xtal_run));

    p_lock_needs_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pll1_ok) || $rose(pll2_ok)) |-> $past(pll_tmr));

    p_drop_with_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll2_run) |-> !pll2_ok);

    p_mul_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pll1_mul >= MUL_W'(MUL_BIAS)) && (pll1_mul <= MUL_W'(63 + MUL_BIAS)));

endmodule

bind osc_pll_ctrl osc_pll_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .main_xtal_run (main_xtal_run),
    .pll2_run      (pll2_run),
    .main_xtal_ok  (main_xtal_ok),
    .pll1_ok       (pll1_ok),
    .pll2_ok       (pll2_ok),
    .pll_tmr       (pll_tmr),
    .pll1_mul      (pll1_mul)
);

// File: tb/osc_pll_ctrl_test.sv
module osc_pll_ctrl_test;

    localparam int CLK_P  = 10;
    localparam int LOCKN  = 5;
    localparam int RW     = 16;
    localparam int OW     = RW + 7;

    localparam int O_RDATA = 0, O_MXOK = 1, O_P1OK = 2, O_P2OK = 3,
                   O_MXRUN = 4, O_SXRUN = 5, O_P1RUN = 6, O_P2RUN = 7,
                   O_P1MUL = 8, O_P1SH = 9, O_P2MUL = 10, O_P1RATE = 11,
                   O_P2RATE = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [RW-1:0]   ref_rate = '0;
    logic            main_xtal_run, slow_xtal_run, pll1_run, pll2_run;
    logic            main_xtal_ok, pll1_ok, pll2_ok;
    logic [6:0]      pll1_mul, pll2_mul;
    logic [2:0]      pll1_shift;
    logic [OW-1:0]   pll1_rate, pll2_rate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    event     sb_ev;

    osc_pll_ctrl #(.ADDR_W(8), .RATE_W(RW), .LOCK_CYCLES(LOCKN)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ref_rate      (ref_rate),
        .main_xtal_run (main_xtal_run),
        .slow_xtal_run (slow_xtal_run),
        .pll1_run      (pll1_run),
        .pll2_run      (pll2_run),
        .main_xtal_ok  (main_xtal_ok),
        .pll1_ok       (pll1_ok),
        .pll2_ok       (pll2_ok),
        .pll1_mul      (pll1_mul),
        .pll1_shift    (pll1_shift),
        .pll2_mul      (pll2_mul),
        .pll1_rate     (pll1_rate),
        .pll2_rate     (pll2_rate)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            O_RDATA:  return reg_rdata;
            O_MXOK:   return 32'(main_xtal_ok);
            O_P1OK:   return 32'(pll1_ok);
            O_P2OK:   return 32'(pll2_ok);
            O_MXRUN:  return 32'(main_xtal_run);
            O_SXRUN:  return 32'(slow_xtal_run);
            O_P1RUN:  return 32'(pll1_run);
            O_P2RUN:  return 32'(pll2_run);
            O_P1MUL:  return 32'(pll1_mul);
            O_P1SH:   return 32'(pll1_shift);
            O_P2MUL:  return 32'(pll2_mul);
            O_P1RATE: return 32'(pll1_rate);
            O_P2RATE: return 32'(pll2_rate);
            default:  return 32'hDEAD_BEEF;
        endcase
    endfunction

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb.size() != 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    // driver side
    task automatic expect_v(int sel, logic [31:0] exp, string tag);
        sb_item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        -> sb_ev;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        expect_v(O_RDATA, exp, tag);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;

        // R11 reset state, R1 read map
        expect_v(O_MXRUN, 1, "R11 main crystal runs after reset");
        expect_v(O_P1RUN, 1, "R11 pll1 runs after reset");
        expect_v(O_P2RUN, 0, "R11 pll2 off after reset");
        expect_v(O_SXRUN, 1, "R11 slow crystal runs after reset");
        expect_v(O_MXOK, 0, "R11 no stable flag at reset");
        expect_v(O_P2OK, 0, "R11 pll2 flag at reset");
        rd_chk(8'h0C, 32'h0010_0000, "R11 R1 crystal word reset");
        rd_chk(8'h10, 32'h2000_0000, "R11 R1 pll word reset");
        rd_chk(8'h14, 32'h0000_0000, "R11 R1 freq word reset");
        rd_chk(8'h00, 32'h0000_0000, "R1 unmapped offset reads zero");

        // hardware-controlled sources settle
        cyc(2 * LOCKN + 2);
        expect_v(O_MXOK, 1, "R5 main crystal stable under hardware");
        expect_v(O_P1OK, 1, "R5 pll1 stable under hardware");
        rd_chk(8'h0C, 32'h0010_0004, "R8 crystal status reads set");
        rd_chk(8'h10, 32'h2000_0004, "R8 pll status reads set");

        // R2 override with enable low stops the crystal; R7 flag drops same cycle
        wr(8'h0C, 32'h0010_0001);
        expect_v(O_MXRUN, 0, "R2 override with enable low");
        expect_v(O_MXOK, 0, "R7 flag drops with run");
        rd_chk(8'h0C, 32'h0010_0001, "R2 crystal word readback");

        // R8 status bit write ignored
        wr(8'h0C, 32'h0010_0005);
        rd_chk(8'h0C, 32'h0010_0001, "R8 status write ignored");
        expect_v(O_MXOK, 0, "R8 status write does not set flag");

        // R5 exact settle timing
        wr(8'h0C, 32'h0010_0003);
        expect_v(O_MXRUN, 1, "R2 override with enable high");
        cyc(LOCKN);
        expect_v(O_MXOK, 0, "R5 not stable one edge early");
        cyc(1);
        expect_v(O_MXOK, 1, "R5 stable on the expected edge");

        // R2 warm-restart: clearing override restarts the crystal
        wr(8'h0C, 32'h0010_0001);
        expect_v(O_MXRUN, 0, "R2 crystal stopped");
        wr(8'h0C, 32'h0010_0000);
        expect_v(O_MXRUN, 1, "R2 clearing override restarts crystal");

        // R6 crystal timer gating
        wr(8'h0C, 32'h0000_0001);
        wr(8'h0C, 32'h0000_0003);
        cyc(3 * LOCKN);
        expect_v(O_MXOK, 0, "R6 timer off holds crystal unstable");
        wr(8'h0C, 32'h0010_0003);
        cyc(LOCKN - 1);
        expect_v(O_MXOK, 0, "R6 count resumes, not yet stable");
        cyc(1);
        expect_v(O_MXOK, 1, "R6 stable after timed edges");

        // R4 slow crystal
        wr(8'h0C, 32'h0018_0003);
        expect_v(O_SXRUN, 0, "R4 slow crystal disabled");
        expect_v(O_MXOK, 1, "R4 slow disable leaves main crystal");
        wr(8'h0C, 32'h0010_0003);
        expect_v(O_SXRUN, 1, "R4 slow crystal re-enabled");

        // R3 PLL1 override
        wr(8'h10, 32'h2000_0001);
        expect_v(O_P1RUN, 0, "R3 pll1 override enable low");
        expect_v(O_P1OK, 0, "R7 pll1 flag drops");
        wr(8'h10, 32'h2000_0003);
        expect_v(O_P1RUN, 1, "R3 pll1 override enable high");
        cyc(LOCKN);
        expect_v(O_P1OK, 0, "R5 pll1 not stable early");
        cyc(1);
        expect_v(O_P1OK, 1, "R5 pll1 stable on time");

        // R4 PLL2, R6 shared PLL timer
        wr(8'h10, 32'h1000_0003);
        expect_v(O_P2RUN, 1, "R4 pll2 follows its enable");
        cyc(3 * LOCKN);
        expect_v(O_P2OK, 0, "R6 pll timer off holds pll2");
        expect_v(O_P1OK, 1, "R6 locked pll1 stays stable");
        rd_chk(8'h10, 32'h1000_0007, "R1 pll word readback");
        wr(8'h10, 32'h3000_0003);
        cyc(LOCKN - 1);
        expect_v(O_P2OK, 0, "R6 pll2 not yet stable");
        cyc(1);
        expect_v(O_P2OK, 1, "R6 pll2 stable after timed edges");
        wr(8'h10, 32'h2000_0003);
        expect_v(O_P2RUN, 0, "R4 pll2 disabled");
        expect_v(O_P2OK, 0, "R7 pll2 flag drops with run");

        // R9 R10 rate decode
        ref_rate = 16'd1000;
        wr(8'h14, 32'h0500_0A03);
        expect_v(O_P1MUL, 12, "R9 pll1 multiplier");
        expect_v(O_P1SH, 3, "R9 pll1 shift");
        expect_v(O_P1RATE, 1500, "R9 pll1 rate");
        expect_v(O_P2MUL, 7, "R10 pll2 multiplier");
        expect_v(O_P2RATE, 7000, "R10 pll2 rate");
        rd_chk(8'h14, 32'h0500_0A03, "R1 freq word readback");

        ref_rate = 16'hFFFF;
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h3F00_3F07, "R1 freq unused bits read zero");
        expect_v(O_P1MUL, 65, "R9 pll1 max multiplier");
        expect_v(O_P1SH, 7, "R9 pll1 max shift");
        expect_v(O_P1RATE, (65 * 65535) >> 7, "R9 pll1 max rate");
        expect_v(O_P2MUL, 65, "R10 pll2 max multiplier");
        expect_v(O_P2RATE, 65 * 65535, "R10 pll2 max rate");

        wr(8'h14, 32'h0000_0000);
        expect_v(O_P1RATE, 2 * 65535, "R9 pll1 minimum multiplier no shift");
        expect_v(O_P2RATE, 2 * 65535, "R10 pll2 minimum multiplier");

        // R1 write to unmapped offset has no effect
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h0010_0007, "R1 stray write leaves crystal word");
        rd_chk(8'h10, 32'h2000_0007, "R1 stray write leaves pll word");
        rd_chk(8'h14, 32'h0000_0000, "R1 stray write leaves freq word");

        cyc(2);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule